// File: doc/BRIEF.md
# Programmable Parallel I/O Port

This block gives an 8-bit CPU bus access to 24 parallel I/O lines. The lines are grouped as two full 8-bit ports (A and B) and a third port C that is split into an upper and a lower 4-bit half. A two-bit address selects one of the three port registers or the control register. The CPU writes the control register to make each of the four groups an input or an output. It reads and writes the ports to move data.

Only the basic I/O mode is built. Output data sits in registers that drive the pins and a per-pin output enable. Input data is not latched: a read of an input group returns the pin levels on the same cycle. A control write with the top bit clear does not change the configuration. Instead it sets or clears one port C line, so software can toggle a single strobe or select line without a read-modify-write.

Top module: `pio_port24`

## Requirements
- R1: After reset, all four groups are inputs (every output enable is 0), all output registers are 0, and a read at address 3 returns 0x9B.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. A write to a port address loads that port's output register, and the new value appears on the port's output pins after the next rising clock edge.
- R3: A control write with bit 7 = 1 sets the group directions from these bits: bit 4 for port A, bit 3 for the upper half of port C, bit 1 for port B and bit 0 for the lower half of port C. A 1 makes the group an input (enables 0) and a 0 makes it an output (enables 1).
- R4: A control write with bit 7 = 1 clears all three output registers to 0.
- R5: The mode bits (6:5 for port A, 2 for port B) of a configuration word are ignored. Every configuration behaves as basic I/O mode, and the word reads back at address 3 exactly as written.
- R6: A read of a group configured as input returns the current input pins, with no register in the path, so a pin change shows in the same cycle.
- R7: A read of a group configured as output returns its output register, not the pins.
- R8: The two halves of port C are read independently. A read at address 2 combines the input half's pins with the output half's register bits.
- R9: A control write with bit 7 = 0 sets port C line number bits 3:1 to the value of bit 0. All other port C register bits are unchanged.
- R10: A single-bit control write changes neither the output enables nor the value read back at address 3.
- R11: With no write, all output registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output register |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench checks port C with one half input and the other half output. A design that steers the read per whole port, not per half, would return the wrong nibble there. It checks that a configuration write clears output registers that already hold data. It also checks that mode bits in that word change nothing, which a design that decodes them would get wrong. It runs single-bit writes that clear a bit already set, that set bit 0, and that set a bit in a half configured as input. A design that ORs instead of writing, gets the index off by one, or lets the write touch the directions or the readback would fail these. It also changes an input pin between two reads with no clock edge between them, which exposes a design that latches inputs.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PORT_W   = 8;
  localparam int HALF_W   = PORT_W / 2;
  localparam int IDX_W    = $clog2(PORT_W);
  localparam logic [PORT_W-1:0] CTL_RESET = 8'h9B;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } pio_sel_e;

  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } pio_dir_t;

  function automatic pio_dir_t f_dir(input logic [PORT_W-1:0] w);
    pio_dir_t d;
    d.a_in  = w[4];
    d.cu_in = w[3];
    d.b_in  = w[1];
    d.cl_in = w[0];
    return d;
  endfunction

  function automatic logic f_is_cfg(input logic [PORT_W-1:0] w);
    return w[PORT_W-1];
  endfunction

  function automatic logic [IDX_W-1:0] f_bit_idx(input logic [PORT_W-1:0] w);
    return w[IDX_W:1];
  endfunction

  // per-half choice between pin and register
  function automatic logic [PORT_W-1:0] f_merge(input logic [PORT_W-1:0] q,
                                                 input logic [PORT_W-1:0] pin,
                                                 input logic hi_in,
                                                 input logic lo_in);
    logic [PORT_W-1:0] r;
    r[PORT_W-1:HALF_W] = hi_in ? pin[PORT_W-1:HALF_W] : q[PORT_W-1:HALF_W];
    r[HALF_W-1:0]      = lo_in ? pin[HALF_W-1:0]      : q[HALF_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] ctl_q,
  output pio_dir_t          dir,
  output logic              ev_mode_wr,
  output logic              ev_bsr_wr
);
  assign ev_mode_wr = ctl_wr &  f_is_cfg(wdata);
  assign ev_bsr_wr  = ctl_wr & ~f_is_cfg(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctl_q <= CTL_RESET;
    else if (ev_mode_wr) ctl_q <= wdata;
  end

  assign dir = f_dir(ctl_q);
endmodule

// File: rtl/pio_out_reg.sv
module pio_out_reg #(
  parameter int W       = 8,
  parameter bit BIT_OPS = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 ld,
  input  logic [W-1:0]         d,
  input  logic                 bit_we,
  input  logic [$clog2(W)-1:0] bit_idx,
  input  logic                 bit_val,
  output logic [W-1:0]         q
);
  logic bit_we_eff;

  generate
    if (BIT_OPS) begin : g_bits
      assign bit_we_eff = bit_we;
    end else begin : g_nobits
      assign bit_we_eff = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clr)        q <= '0;
    else if (ld)         q <= d;
    else if (bit_we_eff) q[bit_idx] <= bit_val;
  end
endmodule

// File: rtl/pio_port24.sv
module pio_port24
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  logic [PORT_W-1:0] ctl_q;
  pio_dir_t          dir;
  logic              ev_mode_wr, ev_bsr_wr;
  logic              wr_a, wr_b, wr_c, wr_ctl;
  pio_sel_e          sel;

  assign sel    = pio_sel_e'(addr);
  assign wr_a   = wr_en && (sel == SEL_A);
  assign wr_b   = wr_en && (sel == SEL_B);
  assign wr_c   = wr_en && (sel == SEL_C);
  assign wr_ctl = wr_en && (sel == SEL_CTL);

  pio_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(wr_ctl), .wdata(wdata),
    .ctl_q(ctl_q), .dir(dir), .ev_mode_wr(ev_mode_wr), .ev_bsr_wr(ev_bsr_wr)
  );

  pio_out_reg #(.W(PORT_W), .BIT_OPS(1'b0)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .clr(ev_mode_wr), .ld(wr_a), .d(wdata),
    .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pa_out)
  );

  pio_out_reg #(.W(PORT_W), .BIT_OPS(1'b0)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .clr(ev_mode_wr), .ld(wr_b), .d(wdata),
    .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pb_out)
  );

  pio_out_reg #(.W(PORT_W), .BIT_OPS(1'b1)) u_reg_c (
    .clk(clk), .rst_n(rst_n), .clr(ev_mode_wr), .ld(wr_c), .d(wdata),
    .bit_we(ev_bsr_wr), .bit_idx(f_bit_idx(wdata)), .bit_val(wdata[0]),
    .q(pc_out)
  );

  assign pa_oe = {PORT_W{~dir.a_in}};
  assign pb_oe = {PORT_W{~dir.b_in}};
  assign pc_oe = {{HALF_W{~dir.cu_in}}, {HALF_W{~dir.cl_in}}};

  always_comb begin
    unique case (sel)
      SEL_A:   rdata = f_merge(pa_out, pa_in, dir.a_in,  dir.a_in);
      SEL_B:   rdata = f_merge(pb_out, pb_in, dir.b_in,  dir.b_in);
      SEL_C:   rdata = f_merge(pc_out, pc_in, dir.cu_in, dir.cl_in);
      default: rdata = ctl_q;
    endcase
  end
endmodule

// File: rtl/pio_port24_chk.sv
module pio_port24_chk
  import pio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        addr,
  input logic              wr_en,
  input logic [PORT_W-1:0] wdata,
  input logic [PORT_W-1:0] rdata,
  input logic [PORT_W-1:0] pa_in,
  input logic [PORT_W-1:0] pa_out,
  input logic [PORT_W-1:0] pa_oe,
  input logic [PORT_W-1:0] pb_out,
  input logic [PORT_W-1:0] pb_oe,
  input logic [PORT_W-1:0] pc_out,
  input logic [PORT_W-1:0] pc_oe,
  input logic              ev_mode_wr,
  input logic              ev_bsr_wr
);
  p_mode_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mode_wr |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

  p_bsr_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bsr_wr |=> pc_out[$past(wdata[3:1])] == $past(wdata[0]));

  p_bsr_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bsr_wr |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

  p_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0 && pa_oe == '0) |-> rdata == pa_in);

  p_group_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1) &&
     $countones(pc_oe[7:4]) inside {0, 4} && $countones(pc_oe[3:0]) inside {0, 4}));
endmodule

bind pio_port24 pio_port24_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe),
  .ev_mode_wr(ev_mode_wr), .ev_bsr_wr(ev_bsr_wr)
);

// File: tb/pio_port24_bench.sv
module pio_port24_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pa_in, pb_in, pc_in;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  pio_port24 u_pio_port24 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  function automatic logic [7:0] observe(input int s);
    case (s)
      0: return rdata;
      1: return pa_out;
      2: return pb_out;
      3: return pc_out;
      4: return pa_oe;
      5: return pb_oe;
      default: return pc_oe;
    endcase
  endfunction

  task automatic expect_val(input int s, input logic [7:0] e, input string tag);
    item_t it;
    it.sel = s; it.exp = e; it.tag = tag;
    sb.push_back(it);
    #2;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a;
    expect_val(0, e, tag);
  endtask

  // monitor: compares queued items between clock edges
  initial begin
    forever begin
      wait (sb.size() > 0);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (observe(it.sel) !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel,
                   observe(it.sel), it.exp);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    pa_in = 8'h11; pb_in = 8'h22; pc_in = 8'h33;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_read(2'd3, 8'h9B, "R1 ctl reset");
    expect_val(4, 8'h00, "R1 pa_oe");
    expect_val(5, 8'h00, "R1 pb_oe");
    expect_val(6, 8'h00, "R1 pc_oe");
    expect_val(3, 8'h00, "R1 pc_out");
    @(negedge clk) rst_n = 1'b1;

    // R3 all outputs
    bus_write(2'd3, 8'h80);
    expect_val(4, 8'hFF, "R3 pa_oe");
    expect_val(5, 8'hFF, "R3 pb_oe");
    expect_val(6, 8'hFF, "R3 pc_oe");

    // R2 port writes
    bus_write(2'd0, 8'hA5);
    expect_val(1, 8'hA5, "R2 pa_out");
    bus_write(2'd1, 8'h3C);
    expect_val(2, 8'h3C, "R2 pb_out");
    bus_write(2'd2, 8'h96);
    expect_val(3, 8'h96, "R2 pc_out");
    // R7 output readback from register
    bus_read(2'd0, 8'hA5, "R7 read A");
    bus_read(2'd1, 8'h3C, "R7 read B");

    // R11 hold
    repeat (3) @(negedge clk);
    expect_val(1, 8'hA5, "R11 pa hold");
    expect_val(3, 8'h96, "R11 pc hold");

    // R9 single-bit writes
    bus_write(2'd3, 8'h0E);   // bit 7 := 0
    expect_val(3, 8'h16, "R9 clear bit7");
    bus_write(2'd3, 8'h01);   // bit 0 := 1
    expect_val(3, 8'h17, "R9 set bit0");
    // R10
    expect_val(4, 8'hFF, "R10 pa_oe");
    expect_val(6, 8'hFF, "R10 pc_oe");
    bus_read(2'd3, 8'h80, "R10 ctl readback");

    // R4/R5: config with mode bits set
    bus_write(2'd3, 8'hE4);
    expect_val(1, 8'h00, "R4 pa cleared");
    expect_val(2, 8'h00, "R4 pb cleared");
    expect_val(3, 8'h00, "R4 pc cleared");
    expect_val(4, 8'hFF, "R5 pa_oe");
    expect_val(5, 8'hFF, "R5 pb_oe");
    bus_read(2'd3, 8'hE4, "R5 ctl readback");

    // R3/R6 A and B input
    bus_write(2'd3, 8'h92);
    expect_val(4, 8'h00, "R3 pa input");
    expect_val(5, 8'h00, "R3 pb input");
    expect_val(6, 8'hFF, "R3 pc output");
    pa_in = 8'h5A;
    bus_read(2'd0, 8'h5A, "R6 read A pins");
    pa_in = 8'hC3;
    expect_val(0, 8'hC3, "R6 same-cycle pin change");
    pb_in = 8'h6E;
    bus_read(2'd1, 8'h6E, "R6 read B pins");

    // R8 split port C: upper input, lower output
    bus_write(2'd3, 8'h88);
    expect_val(6, 8'h0F, "R8 pc_oe split");
    bus_write(2'd2, 8'h35);
    expect_val(3, 8'h35, "R8 pc_out");
    pc_in = 8'hA0;
    bus_read(2'd2, 8'hA5, "R8 merged read");

    // R9/R10 bit set in the input half
    bus_write(2'd3, 8'h0D);   // bit 6 := 1
    expect_val(3, 8'h75, "R9 set bit6");
    expect_val(6, 8'h0F, "R10 pc_oe kept");
    bus_read(2'd3, 8'h88, "R10 ctl kept");

    repeat (2) @(negedge clk);
    wait (sb.size() == 0);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule